// File: doc/BRIEF.md
# Serial Constant-Matrix Vector Multiplier

The block multiplies a stream of real input samples by a fixed square coefficient matrix and returns the product vector one element per clock. Samples come in one per enabled clock and are grouped into blocks of N, aligned to a shared modulo-N index counter. Each of the N lanes has a constant table that holds one matrix row, addressed by that counter. Each lane has a multiplier, a product register and an accumulator. When the last sample of a block has been accumulated, the N sums are latched into a holding bank. A multiplexer steered by the same counter then sends them out serially while the next block accumulates.

Lane i (counting from 0) holds matrix row (floor(N/2)+i) mod N. The serial output therefore starts at the middle row and wraps around. The whole pipeline advances only on clocks with the enable high, so an idle input stalls it without losing alignment. For complex data, two copies run side by side, one for the real parts and one for the imaginary parts.

Top module: `serial_matvec`

## Requirements
- R1: `count` is 0 after reset. On every clock with `en` high it steps 0,1,…,N-1,0,… and on clocks with `en` low it holds its value.
- R2: Lane i (0-based) holds matrix row (floor(N/2)+i) mod N. Address a of that lane's table is column a. The coefficients are packed in `UT_COEFS` with element (row r, column c) at bits [(r*N+c)*16 +: 16].
- R3: A block is N enabled samples x0…x(N-1), taken at counter values 0…N-1. For that block, lane i produces the exact sum over c of xc times the coefficient (row, c) of its row.
- R4: Each block's sums are independent of all earlier blocks. An accumulator restarts from the block's first product.
- R5: The N results of a block come out in lane order 0…N-1, so the rows appear as floor(N/2), floor(N/2)+1, …, wrapping mod N. For N=4 the order is rows 2,3,0,1.
- R6: Suppose the last sample of a block enters on enabled edge t (edges counted from 0 after reset). Its N results then appear on the enabled edges t+2 … t+N+1, one per edge. With no stalls, a valid result follows every enabled edge from edge N+1 onwards.
- R7: `result_valid` is high only in the cycle after an enabled edge. A clock with `en` low produces no result, and the sample on that clock has no effect on any later result.
- R8: A synchronous active-high reset clears `count`, `result` and `result_valid`. After reset, no result is flagged before enabled edge N+1.
- R9: Samples are 5-bit two's complement and coefficients are 16-bit two's complement. The results are exact at full width (SW+CW+clog2(N) bits), with no overflow even for -16 times -32768 in every term.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Sample enable; advances the whole pipeline |
| sample | input | SW | Signed input sample |
| result | output | ACC_W | Signed serial result element |
| result_valid | output | 1 | Result strobe for the current `result` |
| count | output | AW | Shared modulo-N index counter |

## Verification
A wrong lane-to-row mapping or a wrong mux offset shows at the ports as results in the wrong row order. This appears on the first block, N+1 enabled edges after reset. An accumulator that fails to restart, or a product register that is skipped, corrupts the values of the second block or shifts every result by one sample. A counter or stall fault appears on the `count` port at the next clock, and it also shifts the edge at which `result_valid` first rises. The samples driven during stalls are non-zero, so a pipeline that ignores the enable gives wrong values in the following block.

// File: rtl/smv_pkg.sv
`timescale 1ns/1ps
package smv_pkg;
  // Matrix row assigned to lane i: rotation starting at the middle row.
  function automatic int lane_row(input int i, input int n);
    return (n / 2 + i) % n;
  endfunction

  // Width of an index counter for n positions (at least one bit).
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/smv_coef_rom.sv
`timescale 1ns/1ps
module smv_coef_rom #(
  parameter int N = 4,
  parameter int CW = 16,
  parameter int ROW = 0,
  parameter logic [N*N*CW-1:0] COEFS = '0,
  localparam int AW = smv_pkg::idx_width(N)
) (
  input  logic [AW-1:0]        addr,
  output logic signed [CW-1:0] coef
);
  // Constant table: one matrix row, address selects the column.
  logic [CW-1:0] table_q [N];

  always_comb begin
    for (int c = 0; c < N; c++) begin
      table_q[c] = COEFS[(ROW*N+c)*CW +: CW];
    end
  end

  assign coef = $signed(table_q[addr]);
endmodule

// File: rtl/smv_lane.sv
`timescale 1ns/1ps
module smv_lane #(
  parameter int SW = 5,
  parameter int CW = 16,
  parameter int ACC_W = 23,
  localparam int PW = SW + CW
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic signed [SW-1:0]    x,
  input  logic signed [CW-1:0]    coef,
  input  logic                    prod_vld,
  input  logic                    restart,
  output logic signed [ACC_W-1:0] sum
);
  logic signed [PW-1:0]    prod_q;
  logic signed [ACC_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      acc_q  <= '0;
    end else if (en) begin
      prod_q <= PW'(x) * PW'(coef);
      if (prod_vld) begin
        if (restart) acc_q <= ACC_W'(prod_q);
        else         acc_q <= acc_q + ACC_W'(prod_q);
      end
    end
  end

  // Completed block sum, valid when the last product is being absorbed.
  assign sum = acc_q + ACC_W'(prod_q);
endmodule

// File: rtl/smv_serializer.sv
`timescale 1ns/1ps
module smv_serializer #(
  parameter int N = 4,
  parameter int ACC_W = 23,
  localparam int AW = smv_pkg::idx_width(N)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               load,
  input  logic [N*ACC_W-1:0] sums,
  input  logic [AW-1:0]      sel,
  output logic [ACC_W-1:0]   y,
  output logic               y_vld
);
  logic [ACC_W-1:0] hold_q [N];
  logic             hold_vld_q;

  always_ff @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < N; i++) hold_q[i] <= sums[i*ACC_W +: ACC_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_vld_q <= 1'b0;
      y          <= '0;
      y_vld      <= 1'b0;
    end else begin
      if (load) hold_vld_q <= 1'b1;
      y_vld <= en && hold_vld_q;
      if (en && hold_vld_q) y <= hold_q[sel];
    end
  end
endmodule

// File: rtl/serial_matvec.sv
`timescale 1ns/1ps
module serial_matvec #(
  parameter int N = 4,
  parameter int SW = 5,
  parameter int CW = 16,
  parameter logic [N*N*CW-1:0] UT_COEFS = {
    -16'sd12000, 16'sd12000, -16'sd7, 16'sd7,
    -16'sd400, 16'sd300, -16'sd200, 16'sd100,
    16'sd89, -16'sd567, 16'sd1234, 16'h8000,
    16'sd32767, -16'sd4096, 16'sd8192, 16'sd16384
  },
  localparam int AW = smv_pkg::idx_width(N),
  localparam int ACC_W = SW + CW + $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [SW-1:0] sample,
  output logic [ACC_W-1:0]     result,
  output logic                 result_valid,
  output logic [AW-1:0]        count
);
  localparam logic [AW-1:0] LAST = AW'(N - 1);

  logic [AW-1:0]      cnt_q;
  logic [AW-1:0]      pidx_q;
  logic               pvld_q;
  logic [N*ACC_W-1:0] sums;
  logic [AW-1:0]      sel;
  logic               dump;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      pidx_q <= '0;
      pvld_q <= 1'b0;
    end else if (en) begin
      cnt_q  <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      pidx_q <= cnt_q;
      pvld_q <= 1'b1;
    end
  end

  assign dump = en && pvld_q && (pidx_q == LAST);
  // Holding bank is read two enabled edges after the dump index, so the
  // lane feeding the output is the counter value minus one.
  assign sel  = (cnt_q == '0) ? LAST : cnt_q - 1'b1;

  for (genvar i = 0; i < N; i++) begin : g_lane
    localparam int ROW = smv_pkg::lane_row(i, N);
    logic signed [CW-1:0]    coef;
    logic signed [ACC_W-1:0] lane_sum;

    smv_coef_rom #(.N(N), .CW(CW), .ROW(ROW), .COEFS(UT_COEFS)) u_rom (
      .addr(cnt_q),
      .coef(coef)
    );

    smv_lane #(.SW(SW), .CW(CW), .ACC_W(ACC_W)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .x       (sample),
      .coef    (coef),
      .prod_vld(pvld_q),
      .restart (pidx_q == '0),
      .sum     (lane_sum)
    );

    assign sums[i*ACC_W +: ACC_W] = lane_sum;
  end

  smv_serializer #(.N(N), .ACC_W(ACC_W)) u_ser (
    .clk  (clk),
    .rst  (rst),
    .en   (en),
    .load (dump),
    .sums (sums),
    .sel  (sel),
    .y    (result),
    .y_vld(result_valid)
  );

  assign count = cnt_q;
endmodule

// File: rtl/serial_matvec_chk.sv
`timescale 1ns/1ps
module serial_matvec_chk #(
  parameter int N = 4,
  parameter int AW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          en,
  input logic          result_valid,
  input logic [AW-1:0] count
);
  logic [31:0] seen_q;

  always_ff @(posedge clk) begin
    if (rst)                    seen_q <= '0;
    else if (en && seen_q < 32'(N + 2)) seen_q <= seen_q + 1;
  end

  // R1
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (en && count == AW'(N - 1)) |=> count == '0);

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (en && count != AW'(N - 1)) |=> count == $past(count) + 1'b1);

  // R1
  cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  // R7
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> !result_valid);

  // R8
  early_valid_chk: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> seen_q >= 32'(N + 2));
endmodule

bind serial_matvec serial_matvec_chk #(.N(N), .AW(AW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .en          (en),
  .result_valid(result_valid),
  .count       (count)
);

// File: tb/serial_matvec_test.sv
`timescale 1ns/1ps
module serial_matvec_test;
  localparam int N = 4;
  localparam int SW = 5;
  localparam int AW = 2;
  localparam int ACC_W = 23;
  localparam int MID = N / 2;
  localparam int NB = 5;            // blocks with real data
  localparam int NS = (NB + 1) * N; // plus one zero flush block

  localparam int UT [N][N] = '{
    '{16384, 8192, -4096, 32767},
    '{-32768, 1234, -567, 89},
    '{100, -200, 300, -400},
    '{7, -7, 12000, -12000}
  };

  localparam int STIM [NS] = '{
    1, 2, 3, 4,
    -16, -16, -16, -16,
    15, 15, 15, 15,
    0, 0, 0, 7,
    -1, 5, -9, 13,
    0, 0, 0, 0
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic signed [SW-1:0] sample = '0;
  logic [ACC_W-1:0] result;
  logic result_valid;
  logic [AW-1:0] count;

  int checks = 0;
  int fails = 0;
  int oidx = 0;
  int ecount = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  serial_matvec uut (
    .clk(clk), .rst(rst), .en(en), .sample(sample),
    .result(result), .result_valid(result_valid), .count(count)
  );

  function automatic int ref_out(input int o);
    int b, row, s;
    b = o / N;
    row = (MID + (o % N)) % N;
    s = 0;
    if (b < NB) begin
      for (int c = 0; c < N; c++) s += STIM[b*N+c] * UT[row][c];
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Output monitor: every flagged result against the integer model (R2 R3 R4 R5 R9)
  always @(negedge clk) begin
    if (mon_on && result_valid) begin
      check(int'($signed(result)) == ref_out(oidx), "R2 R3 R4 R5 R9 result",
            int'($signed(result)), ref_out(oidx));
      oidx++;
    end
  end

  initial begin
    int last_en;
    repeat (3) @(negedge clk);
    // R8 reset state
    check(count == '0, "R8 count at reset", int'(count), 0);
    check(result_valid == 1'b0, "R8 valid at reset", int'(result_valid), 0);
    check(result == '0, "R8 result at reset", int'(result), 0);
    rst = 1'b0;
    mon_on = 1'b1;
    last_en = 0;
    for (int i = 0; i <= NS; i++) begin
      // stall three cycles in the middle of block 2
      if (i == 2 * N + 2) begin
        for (int g = 0; g < 3; g++) begin
          @(negedge clk);
          if (last_en != 0) ecount++;
          if (g > 0) begin
            check(result_valid == 1'b0, "R7 no valid while idle", int'(result_valid), 0);
            check(count == AW'(ecount % N), "R1 count held while idle", int'(count), ecount % N);
          end
          en = 1'b0;
          sample = 5'sd9;
          last_en = 0;
        end
      end
      @(negedge clk);
      if (last_en != 0) begin
        ecount++;
        check(count == AW'(ecount % N), "R1 count step", int'(count), ecount % N);
        check(result_valid == ((ecount - 1) >= N + 1), "R6 R8 valid timing",
              int'(result_valid), int'((ecount - 1) >= N + 1));
      end
      en = 1'b1;
      sample = (i < NS) ? SW'(STIM[i]) : '0;
      last_en = 1;
    end
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    mon_on = 1'b0;
    // R6 every result of every real block emitted exactly once
    check(oidx == NB * N, "R6 result count", oidx, NB * N);

    // R8 mid-stream reset
    en = 1'b1;
    sample = 5'sd3;
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(count == '0, "R8 count after reset", int'(count), 0);
    check(result_valid == 1'b0, "R8 valid after reset", int'(result_valid), 0);
    check(result == '0, "R8 result after reset", int'(result), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule